// File: doc/BRIEF.md
# Halfword Load Address Generation Unit

This unit runs the halfword load instruction of a small core with eight 24-bit registers. It decodes one 16-bit instruction word per accepted operation and works out the memory address for one of four base-register modes: plain, post-increment, post-decrement and pre-decrement. It issues a single read on a synchronous memory port, and the read data returns one cycle later. The unit zero-extends that halfword into the destination register and writes back the adjusted base register when the mode calls for it. The register file sits inside the unit. A debug select input lets the surrounding logic observe any register.

Extension prefix words can come before a load, flagged by `op_is_ext`. Each prefix shifts 13 bits into an immediate collector. The collected immediate becomes a displacement added to the address. In the stepping modes it also replaces the default step of 2. Every load finishes one cycle after its memory request. The completion is reported as either a short (one-cycle) or a long (two-cycle) instruction. A long instruction blocks the next operation during its completion cycle. A short one lets the next operation start in that same cycle, and the just-loaded value is forwarded to it.

Top module: `hwld_agu`

## Requirements
- R1: A non-prefix word is a load when bits 15:10 are 001000 and bits 6:3 are 0010 (plain), 0110 (post-increment), 1110 (post-decrement) or 1010 (pre-decrement); bits 9:7 name the destination and bits 2:0 the base. Any other non-prefix word makes no memory request and changes no register, and a prefix word never makes a request.
- R2: The halfword on `mem_rdata` in the cycle after `mem_req` is written into the destination register as bits 15:0, with bits 23:16 cleared.
- R3: Without a prefix, plain, post-increment and post-decrement loads address the base register value, and pre-decrement addresses the base minus 2.
- R4: Without a prefix, post-increment adds 2 to the base, both decrement modes subtract 2, and a plain load leaves the base unchanged.
- R5: A prefix shifts its bits 12:0 into the low end of the 24-bit immediate. One prefix gives a zero-extended 13-bit value. With two prefixes, bits 10:0 of the first become bits 23:13 and bits 12:0 of the second become bits 12:0.
- R6: With a prefix, plain, post-increment and post-decrement loads address base plus immediate; plain keeps the base, post-increment adds the immediate to it, and post-decrement subtracts it.
- R7: With a prefix, pre-decrement first lowers the base by the immediate and then addresses the lowered base plus the immediate.
- R8: The immediate is discarded once a load uses it, and also when any non-prefix, non-load word is accepted; a later load then acts as if no prefix had been given.
- R9: All base and address arithmetic wraps modulo 2^24.
- R10: `done` is high exactly one cycle after `mem_req`. `done_long` is high with it when a prefix was used or the mode is not plain. `op_ready` is low in the completion cycle of a long load and high in that of a short load.
- R11: When destination and base are the same register in a stepping mode, the register ends up holding the loaded data.
- R12: A load accepted in the completion cycle of a short load uses the newly loaded value when its base is that load's destination.
- R13: After reset all registers read zero, `op_ready` is high, and `done` and `mem_req` are low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| op_valid | input | 1 | An operation word is offered |
| op_is_ext | input | 1 | The offered word is an extension prefix |
| op_word | input | 16 | Instruction word or prefix payload |
| op_ready | output | 1 | The unit accepts an operation this cycle |
| mem_req | output | 1 | Halfword read request |
| mem_addr | output | 24 | Read address |
| mem_rdata | input | 16 | Read data, valid one cycle after the request |
| done | output | 1 | A load completes this cycle |
| done_long | output | 1 | The completing load is a two-cycle instruction |
| dbg_sel | input | 3 | Register selected for observation |
| dbg_data | output | 24 | Contents of the selected register |

## Verification
Each of the four modes is run without a prefix, with a single 13-bit prefix and with a two-word 24-bit prefix. Comparing these runs separates the default step of 2 from the immediate step, and displacement addressing from plain base addressing. The bench's memory returns data that depends on the address. This makes every register value a check of the address that produced it, and the destination value also shows whether the base update or the load data won when the two registers coincide. Three further patterns are used. A pre-decrement from zero and a 24-bit all-ones immediate exercise wraparound. A prefix followed by an invalid word shows whether the prefix was dropped. Back-to-back short loads that share a register show whether forwarding works, because stale data would produce a different address.

// File: rtl/hwld_pkg.sv
package hwld_pkg;

   localparam int unsigned INSTR_W = 16;
   localparam logic [5:0]  LD_MAJOR = 6'b001000;

   typedef enum logic [1:0] {
      AM_PLAIN   = 2'd0,
      AM_POSTINC = 2'd1,
      AM_POSTDEC = 2'd2,
      AM_PREDEC  = 2'd3
   } addr_mode_e;

   typedef struct packed {
      logic       is_load;
      logic [2:0] dst;
      logic [2:0] src;
      addr_mode_e mode;
   } ld_dec_t;

   function automatic ld_dec_t ld_decode(input logic [INSTR_W-1:0] w);
      ld_dec_t d;
      d.dst     = w[9:7];
      d.src     = w[2:0];
      d.is_load = (w[15:10] == LD_MAJOR);
      d.mode    = AM_PLAIN;
      case (w[6:3])
         4'b0010: d.mode = AM_PLAIN;
         4'b0110: d.mode = AM_POSTINC;
         4'b1110: d.mode = AM_POSTDEC;
         4'b1010: d.mode = AM_PREDEC;
         default: d.is_load = 1'b0;
      endcase
      return d;
   endfunction

endpackage

// File: rtl/hwld_prefix.sv
module hwld_prefix #(
   parameter int unsigned XLEN   = 24,
   parameter int unsigned EXT_LO = 13
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              shift_en,
   input  logic              clear,
   input  logic [EXT_LO-1:0] payload,
   output logic [XLEN-1:0]   imm,
   output logic              present
);
   localparam int unsigned KEEP = XLEN - EXT_LO;

   if (XLEN <= EXT_LO) begin : g_bad_len
      $error("hwld_prefix: XLEN must exceed EXT_LO");
   end
   if (XLEN > 2 * EXT_LO) begin : g_bad_fill
      $error("hwld_prefix: two prefixes must fill XLEN");
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         imm     <= '0;
         present <= 1'b0;
      end else if (shift_en) begin
         imm     <= {imm[KEEP-1:0], payload};
         present <= 1'b1;
      end else if (clear) begin
         imm     <= '0;
         present <= 1'b0;
      end
   end
endmodule

// File: rtl/hwld_addr.sv
module hwld_addr
   import hwld_pkg::*;
#(
   parameter int unsigned XLEN = 24
) (
   input  logic [XLEN-1:0] base,
   input  logic [XLEN-1:0] imm,
   input  logic            has_imm,
   input  addr_mode_e      mode,
   output logic [XLEN-1:0] addr,
   output logic [XLEN-1:0] new_base,
   output logic            upd,
   output logic            long_op
);
   localparam logic [XLEN-1:0] DEF_STEP = XLEN'(2);

   logic [XLEN-1:0] step;
   logic [XLEN-1:0] disp;
   logic [XLEN-1:0] lowered;
   logic [XLEN-1:0] raised;

   assign step    = has_imm ? imm : DEF_STEP;
   assign disp    = has_imm ? imm : '0;
   assign lowered = base - step;
   assign raised  = base + step;

   always_comb begin
      addr     = base + disp;
      new_base = lowered;
      upd      = 1'b1;
      unique case (mode)
         AM_PLAIN: begin
            new_base = base;
            upd      = 1'b0;
         end
         AM_POSTINC: new_base = raised;
         AM_POSTDEC: new_base = lowered;
         AM_PREDEC:  addr     = lowered + disp;
         default:    upd      = 1'b0;
      endcase
   end

   assign long_op = has_imm | upd;
endmodule

// File: rtl/hwld_regfile.sv
module hwld_regfile #(
   parameter int unsigned XLEN = 24,
   parameter int unsigned NREG = 8
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    wa_en,
   input  logic [$clog2(NREG)-1:0] wa_idx,
   input  logic [XLEN-1:0]         wa_data,
   input  logic                    wb_en,
   input  logic [$clog2(NREG)-1:0] wb_idx,
   input  logic [XLEN-1:0]         wb_data,
   input  logic [$clog2(NREG)-1:0] ra_idx,
   output logic [XLEN-1:0]         ra_data,
   input  logic [$clog2(NREG)-1:0] rd_idx,
   output logic [XLEN-1:0]         rd_data
);
   localparam int unsigned IW = $clog2(NREG);

   if (NREG < 2) begin : g_bad_nreg
      $error("hwld_regfile: need at least two registers");
   end

   logic [NREG-1:0][XLEN-1:0] rows;

   for (genvar g = 0; g < NREG; g++) begin : g_row
      logic [XLEN-1:0] q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            q <= '0;
         end else if (wb_en && (wb_idx == IW'(g))) begin
            q <= wb_data;
         end else if (wa_en && (wa_idx == IW'(g))) begin
            q <= wa_data;
         end
      end
      assign rows[g] = q;
   end

   assign ra_data = rows[ra_idx];
   assign rd_data = rows[rd_idx];
endmodule

// File: rtl/hwld_agu.sv
module hwld_agu
   import hwld_pkg::*;
#(
   parameter int unsigned XLEN   = 24,
   parameter int unsigned DLEN   = 16,
   parameter int unsigned EXT_LO = 13,
   parameter bit          FWD_EN = 1'b1
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                op_valid,
   input  logic                op_is_ext,
   input  logic [INSTR_W-1:0]  op_word,
   output logic                op_ready,
   output logic                mem_req,
   output logic [XLEN-1:0]     mem_addr,
   input  logic [DLEN-1:0]     mem_rdata,
   output logic                done,
   output logic                done_long,
   input  logic [2:0]          dbg_sel,
   output logic [XLEN-1:0]     dbg_data
);
   localparam int unsigned NREG = 8;
   localparam int unsigned IW   = $clog2(NREG);

   if (DLEN >= XLEN) begin : g_bad_dlen
      $error("hwld_agu: DLEN must be narrower than XLEN");
   end
   if (EXT_LO >= INSTR_W) begin : g_bad_ext
      $error("hwld_agu: prefix payload must fit the word");
   end

   ld_dec_t         dec;
   logic            take;
   logic            acc_load;
   logic            acc_pfx;
   logic            acc_other;
   logic [XLEN-1:0] imm;
   logic            has_imm;
   logic [XLEN-1:0] rf_base;
   logic [XLEN-1:0] base;
   logic [XLEN-1:0] ld_ext;
   logic [XLEN-1:0] addr;
   logic [XLEN-1:0] new_base;
   logic            upd;
   logic            long_op;

   logic            pend_valid;
   logic            pend_long;
   logic            pend_upd;
   logic [IW-1:0]   pend_dst;
   logic [IW-1:0]   pend_src;
   logic [XLEN-1:0] pend_nb;

   assign dec       = ld_decode(op_word);
   assign take      = op_valid & op_ready;
   assign acc_pfx   = take & op_is_ext;
   assign acc_load  = take & ~op_is_ext & dec.is_load;
   assign acc_other = take & ~op_is_ext & ~dec.is_load;

   assign ld_ext = {{(XLEN-DLEN){1'b0}}, mem_rdata};

   hwld_prefix #(.XLEN(XLEN), .EXT_LO(EXT_LO)) u_prefix (
      .clk      (clk),
      .rst_n    (rst_n),
      .shift_en (acc_pfx),
      .clear    (acc_load | acc_other),
      .payload  (op_word[EXT_LO-1:0]),
      .imm      (imm),
      .present  (has_imm)
   );

   hwld_regfile #(.XLEN(XLEN), .NREG(NREG)) u_rf (
      .clk     (clk),
      .rst_n   (rst_n),
      .wa_en   (pend_valid & pend_upd),
      .wa_idx  (pend_src),
      .wa_data (pend_nb),
      .wb_en   (pend_valid),
      .wb_idx  (pend_dst),
      .wb_data (ld_ext),
      .ra_idx  (dec.src),
      .ra_data (rf_base),
      .rd_idx  (dbg_sel),
      .rd_data (dbg_data)
   );

   if (FWD_EN) begin : g_fwd
      assign base     = (pend_valid && (pend_dst == dec.src)) ? ld_ext : rf_base;
      assign op_ready = ~(pend_valid & pend_long);
   end else begin : g_nofwd
      assign base     = rf_base;
      assign op_ready = ~pend_valid;
   end

   hwld_addr #(.XLEN(XLEN)) u_addr (
      .base     (base),
      .imm      (imm),
      .has_imm  (has_imm),
      .mode     (dec.mode),
      .addr     (addr),
      .new_base (new_base),
      .upd      (upd),
      .long_op  (long_op)
   );

   assign mem_req  = acc_load;
   assign mem_addr = addr;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pend_valid <= 1'b0;
         pend_long  <= 1'b0;
         pend_upd   <= 1'b0;
         pend_dst   <= '0;
         pend_src   <= '0;
         pend_nb    <= '0;
      end else begin
         pend_valid <= acc_load;
         if (acc_load) begin
            pend_long <= long_op;
            pend_upd  <= upd;
            pend_dst  <= dec.dst;
            pend_src  <= dec.src;
            pend_nb   <= new_base;
         end
      end
   end

   assign done      = pend_valid;
   assign done_long = pend_valid & pend_long;
endmodule

// File: rtl/hwld_agu_chk.sv
module hwld_agu_chk (
   input logic clk,
   input logic rst_n,
   input logic op_valid,
   input logic op_is_ext,
   input logic op_ready,
   input logic mem_req,
   input logic done,
   input logic done_long
);
   a_r10_done_follows_req: assert property (@(posedge clk) disable iff (!rst_n)
      mem_req |=> done);

   a_r10_done_needs_req: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> $past(mem_req));

   a_r10_long_blocks: assert property (@(posedge clk) disable iff (!rst_n)
      done_long |-> !op_ready);

   a_r10_long_is_done: assert property (@(posedge clk) disable iff (!rst_n)
      done_long |-> done);

   a_r1_prefix_no_req: assert property (@(posedge clk) disable iff (!rst_n)
      (op_valid && op_is_ext) |-> !mem_req);

   a_r1_req_when_taken: assert property (@(posedge clk) disable iff (!rst_n)
      mem_req |-> (op_valid && op_ready));

   a_r13_reset_quiet: assert property (@(posedge clk)
      !rst_n |-> (!mem_req && !done && op_ready));
endmodule

bind hwld_agu hwld_agu_chk chk_i (
   .clk       (clk),
   .rst_n     (rst_n),
   .op_valid  (op_valid),
   .op_is_ext (op_is_ext),
   .op_ready  (op_ready),
   .mem_req   (mem_req),
   .done      (done),
   .done_long (done_long)
);

// File: tb/hwld_agu_tb_top.sv
module hwld_agu_tb_top;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        op_valid = 1'b0;
   logic        op_is_ext = 1'b0;
   logic [15:0] op_word = '0;
   logic        op_ready;
   logic        mem_req;
   logic [23:0] mem_addr;
   logic [15:0] mem_rdata = '0;
   logic        done;
   logic        done_long;
   logic [2:0]  dbg_sel = '0;
   logic [23:0] dbg_data;

   int n_chk = 0;
   int n_bad = 0;
   int cyc = 0;

   always #10 clk = ~clk;

   hwld_agu dut_i (
      .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_is_ext(op_is_ext),
      .op_word(op_word), .op_ready(op_ready), .mem_req(mem_req),
      .mem_addr(mem_addr), .mem_rdata(mem_rdata), .done(done),
      .done_long(done_long), .dbg_sel(dbg_sel), .dbg_data(dbg_data)
   );

   function automatic logic [15:0] mem_fn(input logic [23:0] a);
      return a[15:0] + 16'h0100;
   endfunction

   always @(posedge clk) if (mem_req) mem_rdata <= mem_fn(mem_addr);

   always @(posedge clk) begin
      cyc <= cyc + 1;
      if (cyc > 20000) begin
         n_chk++; n_bad++;
         $display("FAIL watchdog act=%0d exp=<20000", cyc);
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
         $finish;
      end
   end

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s act=%h exp=%h", tag, act, exp);
      end
   endtask

   // reference model built from the requirements
   logic [23:0] m_r [8];
   logic [23:0] m_imm;
   logic        m_pf;

   task automatic m_reset();
      for (int i = 0; i < 8; i++) m_r[i] = '0;
      m_imm = '0; m_pf = 1'b0;
   endtask

   task automatic m_step(input logic ext, input logic [15:0] w,
                         output logic req, output logic [23:0] a, output logic lng);
      logic ok;
      logic [23:0] b, st, ds, nb;
      req = 1'b0; a = '0; lng = 1'b0;
      if (ext) begin
         m_imm = {m_imm[10:0], w[12:0]};
         m_pf  = 1'b1;
         return;
      end
      ok = (w[15:10] == 6'b001000) &&
           (w[6:3] == 4'b0010 || w[6:3] == 4'b0110 || w[6:3] == 4'b1110 || w[6:3] == 4'b1010);
      if (ok) begin
         b  = m_r[w[2:0]];
         st = m_pf ? m_imm : 24'd2;
         ds = m_pf ? m_imm : 24'd0;
         nb = b;
         a  = b + ds;
         if (w[6:3] == 4'b0110) nb = b + st;
         if (w[6:3] == 4'b1110) nb = b - st;
         if (w[6:3] == 4'b1010) begin nb = b - st; a = nb + ds; end
         lng = m_pf || (w[6:3] != 4'b0010);
         m_r[w[2:0]] = nb;
         m_r[w[9:7]] = {8'h00, mem_fn(a)};
         req = 1'b1;
      end
      m_imm = '0; m_pf = 1'b0;
   endtask

   task automatic issue(input logic ext, input logic [15:0] w, input logic ereq,
                        input logic [23:0] eaddr, input logic elng, input string tag);
      for (int g = 0; g < 50 && !op_ready; g++) @(negedge clk);
      op_valid = 1'b1; op_is_ext = ext; op_word = w;
      #1;
      chk({tag, " mem_req"}, 32'(mem_req), 32'(ereq));
      if (ereq) chk({tag, " mem_addr"}, 32'(mem_addr), 32'(eaddr));
      @(negedge clk);
      op_valid = 1'b0; op_is_ext = 1'b0; op_word = '0;
      #1;
      chk({tag, " done"}, 32'(done), 32'(ereq));
      if (ereq) begin
         chk({tag, " done_long"}, 32'(done_long), 32'(elng));
         chk({tag, " R10 op_ready"}, 32'(op_ready), 32'(!elng));
      end
   endtask

   task automatic run(input logic ext, input logic [15:0] w, input string tag);
      logic r, l;
      logic [23:0] a;
      m_step(ext, w, r, a, l);
      issue(ext, w, r, a, l, tag);
   endtask

   task automatic reg_chk(input int idx, input logic [23:0] exp, input string tag);
      @(negedge clk);
      dbg_sel = 3'(idx);
      #1;
      chk(tag, 32'(dbg_data), 32'(exp));
   endtask

   task automatic do_reset();
      op_valid = 1'b0;
      rst_n = 1'b0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      m_reset();
   endtask

   typedef struct packed {
      logic        ext;
      logic [15:0] word;
      logic        req;
      logic [23:0] addr;
      logic        lng;
   } vec_t;

   localparam vec_t VEC [13] = '{
      '{1'b0, 16'h2090, 1'b1, 24'h000000, 1'b0},  // R3 plain
      '{1'b0, 16'h2131, 1'b1, 24'h000100, 1'b1},  // R12 R4 postinc, forwarded base
      '{1'b0, 16'h21F2, 1'b1, 24'h000200, 1'b1},  // R4 postdec
      '{1'b0, 16'h2253, 1'b1, 24'h0002FE, 1'b1},  // R3 predec
      '{1'b1, 16'h0010, 1'b0, 24'h000000, 1'b0},  // R5 prefix
      '{1'b0, 16'h2294, 1'b1, 24'h00040E, 1'b1},  // R6 plain + disp
      '{1'b1, 16'h1FFF, 1'b0, 24'h000000, 1'b0},
      '{1'b0, 16'h2335, 1'b1, 24'h00250D, 1'b1},  // R6 postinc by imm
      '{1'b1, 16'h0001, 1'b0, 24'h000000, 1'b0},
      '{1'b1, 16'h0000, 1'b0, 24'h000000, 1'b0},
      '{1'b0, 16'h23F6, 1'b1, 24'h00460D, 1'b1},  // R5 24-bit imm, postdec
      '{1'b1, 16'h0020, 1'b0, 24'h000000, 1'b0},
      '{1'b0, 16'h2057, 1'b1, 24'h00470D, 1'b1}   // R7 predec with imm
   };

   localparam logic [23:0] FINAL [8] = '{
      24'h00480D, 24'h000102, 24'h0001FE, 24'h0002FE,
      24'h0003FE, 24'h00250D, 24'h00060D, 24'h0046ED
   };

   initial begin
      do_reset();
      // R13 reset state
      chk("R13 op_ready", 32'(op_ready), 32'd1);
      chk("R13 done", 32'(done), 32'd0);
      chk("R13 mem_req", 32'(mem_req), 32'd0);
      for (int i = 0; i < 8; i++) reg_chk(i, 24'h0, "R13 reg zero");

      for (int v = 0; v < 13; v++)
         issue(VEC[v].ext, VEC[v].word, VEC[v].req, VEC[v].addr, VEC[v].lng, "R3-table vector");
      for (int i = 0; i < 8; i++) reg_chk(i, FINAL[i], "R2 R4 R6 R7 table register");

      do_reset();
      run(1'b0, 16'h20D0, "R9 predec wrap");
      run(1'b0, 16'h2130, "R9 postinc wrap");
      reg_chk(0, 24'h000000, "R9 base back to zero");
      reg_chk(1, 24'h0000FE, "R2 zero-extended data");
      run(1'b1, 16'h07FF, "R5 upper prefix");
      run(1'b1, 16'h1FFF, "R5 lower prefix");
      run(1'b0, 16'h21B1, "R5 R9 all-ones immediate");
      reg_chk(1, 24'h0000FD, "R9 base plus -1");
      run(1'b1, 16'h0040, "R8 prefix");
      run(1'b0, 16'h2018, "R1 invalid mode");
      run(1'b0, 16'h2211, "R8 prefix dropped");
      run(1'b0, 16'h4090, "R1 wrong major");
      run(1'b0, 16'h20B1, "R11 dst equals base");
      reg_chk(1, m_r[1], "R11 loaded data wins");
      run(1'b0, 16'h2291, "R12 first load");
      run(1'b0, 16'h2315, "R12 forwarded base");
      run(1'b1, 16'h0004, "R7 prefix");
      run(1'b0, 16'h23D2, "R7 predec with imm");
      for (int i = 0; i < 8; i++) reg_chk(i, m_r[i], "R1 R2 final register");

      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end
endmodule